// File: doc/BRIEF.md
# Accelerator Stream Protocol Controller

This controller sits beside a fixed-function accelerator and its scratchpad. It drives the accelerator's transfer unit through a chunked file protocol with one input channel and one output channel. Software sets up every endpoint beforehand, and the controller never touches endpoint setup. Once it is started, the controller loops on its own. It asks a server for the next input piece and reads that piece into the scratchpad in buffer-sized chunks. It runs the accelerator on each chunk and streams the result into output pieces, which it also obtains from a server.

Each request for a new piece also commits the piece handed out before it, so the steady state needs no commit message. An explicit byte-count commit is sent only once, when an empty input reply marks end of file, to close the partly filled last output piece. The controller has two other exits. A context-switch request takes effect at the next boundary between transfers. An error from the transfer unit leaves a sticky code that stays until reset.

Top module: `asp_stream_ctrl`

## Requirements
- R1: After reset the controller issues no request, no transfer and no accelerator start, and all status outputs are 0. It stays in this state until `go` is pulsed.
- R2: A piece request raises `req_valid` with `req_chan` = 0 for input or 1 for output, and `req_commit` = 0. The request and its fields stay steady until the cycle `req_ready` is seen. On `go`, the first request is for input.
- R3: A nonzero-length input reply starts read transfers (`xfer_write` = 0) into scratchpad offset 0. The reads begin at the reply position and advance by each chunk. Each chunk length is the smaller of the bytes left in the piece and `BUF_BYTES`. `xfer_valid` and its fields stay steady until `xfer_done`.
- R4: After each read chunk completes, `acc_start` is pulsed for exactly one cycle with `acc_len` equal to that chunk's length. The controller then waits for `acc_done`, whose `acc_res_len` gives the number of result bytes.
- R5: Result bytes go out in write transfers (`xfer_write` = 1). Each write has length = the smaller of the result bytes left and the space left in the current output piece. Writes take consecutive output addresses, and the scratchpad offset advances through the result. A new output piece is requested only when the current one has no space left.
- R6: The steady state sends no commit message. When a result is fully written, the controller reads the next chunk of the same input piece, or requests a new input piece if that piece is used up.
- R7: A zero-length input reply means end of file. If bytes were written into the latest output piece, the controller first sends a commit (`req_chan` = 1, `req_commit` = 1, `req_nbytes` = bytes written into that piece). It then raises `st_done` and stays idle.
- R8: `ctx_req` is acted on only where a request or transfer would next be issued. A transfer or computation already under way runs to completion. The controller then raises `st_saved` and issues nothing further until reset.
- R9: Any error sends the controller to `st_err` with a sticky `err_code`. Error codes: 1 = input reply error, 2 = output reply error, 3 = read error, 4 = write error, 5 = output piece of length 0. The code and the error state hold until reset.
- R10: A piece request and a data transfer are never valid in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Start pulse for the processing loop |
| ctx_req | input | 1 | Context-switch request |
| req_valid | output | 1 | Piece request or commit message is valid |
| req_chan | output | 1 | 0 input channel, 1 output channel |
| req_commit | output | 1 | 1 for explicit commit, 0 for next-piece request |
| req_nbytes | output | LEN_W | Byte count of an explicit commit |
| req_ready | input | 1 | Transfer unit accepted the message |
| rsp_valid | input | 1 | Server reply present |
| rsp_err | input | 1 | Reply carries an error |
| rsp_pos | input | ADDR_W | Piece position in the memory endpoint |
| rsp_len | input | LEN_W | Piece length in bytes |
| xfer_valid | output | 1 | Data transfer command valid |
| xfer_write | output | 1 | 1 scratchpad to memory, 0 memory to scratchpad |
| xfer_addr | output | ADDR_W | Memory endpoint byte address |
| xfer_len | output | LEN_W | Transfer length in bytes |
| xfer_spm | output | SPM_W | Scratchpad byte offset |
| xfer_done | input | 1 | Transfer finished |
| xfer_err | input | 1 | Transfer finished with an error |
| acc_start | output | 1 | Accelerator start pulse |
| acc_len | output | LEN_W | Input byte count for this run |
| acc_done | input | 1 | Accelerator finished |
| acc_res_len | input | LEN_W | Result bytes in the scratchpad |
| st_done | output | 1 | End of file handled |
| st_saved | output | 1 | Stopped for a context switch |
| st_err | output | 1 | Stopped on an error |
| err_code | output | 4 | Sticky error code |

## Verification
Every output is decoded from the state register and the chunk and offset registers. A handshake input seen at a rising edge therefore changes the outputs one cycle later: a new request or transfer, the one-cycle `acc_start`, or a status flag. The bench drives each handshake input for exactly one cycle at a falling edge and samples the outputs at falling edges. Each expected request, transfer or start is awaited with a bounded poll before its fields are compared. For the cases that must not act early — context switch during a read, errors, end of file — the bench holds the stimulus for several further cycles and checks that no request or transfer appears.

// File: rtl/asp_pkg.sv
package asp_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_IN_REQ,
    ST_IN_WAIT,
    ST_READ,
    ST_RUN_GO,
    ST_RUN_WAIT,
    ST_OUT_REQ,
    ST_OUT_WAIT,
    ST_WRITE,
    ST_FIN,
    ST_DONE,
    ST_SAVE,
    ST_ERR
  } asp_state_e;

  localparam int ERR_W = 4;

  localparam logic [ERR_W-1:0] ERR_NONE      = 4'd0;
  localparam logic [ERR_W-1:0] ERR_IN_RSP    = 4'd1;
  localparam logic [ERR_W-1:0] ERR_OUT_RSP   = 4'd2;
  localparam logic [ERR_W-1:0] ERR_READ      = 4'd3;
  localparam logic [ERR_W-1:0] ERR_WRITE     = 4'd4;
  localparam logic [ERR_W-1:0] ERR_OUT_EMPTY = 4'd5;

endpackage

// File: rtl/asp_piece_track.sv
// Holds the cursor of one handed-out piece: current address and bytes left.
module asp_piece_track #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_pos,
  input  logic [LEN_W-1:0]  load_len,
  input  logic              adv,
  input  logic [LEN_W-1:0]  adv_n,
  output logic [ADDR_W-1:0] addr,
  output logic [LEN_W-1:0]  remain
);

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic              upd;

  always_comb begin
    upd    = load | adv;
    addr_d = addr_q;
    rem_d  = rem_q;
    if (load) begin
      addr_d = load_pos;
      rem_d  = load_len;
    end else if (adv) begin
      addr_d = addr_q + ADDR_W'(adv_n);
      rem_d  = rem_q - adv_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      rem_q  <= '0;
    end else if (upd) begin
      addr_q <= addr_d;
      rem_q  <= rem_d;
    end
  end

  assign addr   = addr_q;
  assign remain = rem_q;

endmodule

// File: rtl/asp_err_hold.sv
// Captures the first error code and keeps it until reset.
module asp_err_hold #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set,
  input  logic [W-1:0] code_in,
  output logic [W-1:0] code
);

  logic [W-1:0] code_q;
  logic         cap;

  assign cap = set && (code_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
    end else if (cap) begin
      code_q <= code_in;
    end
  end

  assign code = code_q;

endmodule

// File: rtl/asp_stream_ctrl.sv
module asp_stream_ctrl #(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 16,
  parameter int BUF_BYTES = 64,
  localparam int SPM_W    = $clog2(BUF_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              ctx_req,
  output logic              req_valid,
  output logic              req_chan,
  output logic              req_commit,
  output logic [LEN_W-1:0]  req_nbytes,
  input  logic              req_ready,
  input  logic              rsp_valid,
  input  logic              rsp_err,
  input  logic [ADDR_W-1:0] rsp_pos,
  input  logic [LEN_W-1:0]  rsp_len,
  output logic              xfer_valid,
  output logic              xfer_write,
  output logic [ADDR_W-1:0] xfer_addr,
  output logic [LEN_W-1:0]  xfer_len,
  output logic [SPM_W-1:0]  xfer_spm,
  input  logic              xfer_done,
  input  logic              xfer_err,
  output logic              acc_start,
  output logic [LEN_W-1:0]  acc_len,
  input  logic              acc_done,
  input  logic [LEN_W-1:0]  acc_res_len,
  output logic              st_done,
  output logic              st_saved,
  output logic              st_err,
  output logic [3:0]        err_code
);
  import asp_pkg::*;

  localparam logic [LEN_W-1:0] BUF_LEN = LEN_W'(BUF_BYTES);

  asp_state_e state_q, state_d;

  logic [ADDR_W-1:0] in_addr, out_addr;
  logic [LEN_W-1:0]  in_rem, out_rem;
  logic [LEN_W-1:0]  in_chunk, wr_len, res_after;
  logic              in_load, in_adv, out_load, out_adv;

  logic [LEN_W-1:0]  chunk_q;
  logic [LEN_W-1:0]  res_left_q, res_left_d;
  logic [SPM_W-1:0]  res_off_q, res_off_d;
  logic [LEN_W-1:0]  out_used_q, out_used_d;
  logic              chunk_en, res_en, used_en;

  logic              err_set;
  logic [ERR_W-1:0]  err_val;

  // Chunk sizing
  assign in_chunk  = (in_rem > BUF_LEN) ? BUF_LEN : in_rem;
  assign wr_len    = (res_left_q < out_rem) ? res_left_q : out_rem;
  assign res_after = res_left_q - wr_len;

  // Cursor updates
  assign in_load  = (state_q == ST_IN_WAIT)  && rsp_valid && !rsp_err && (rsp_len != '0);
  assign out_load = (state_q == ST_OUT_WAIT) && rsp_valid && !rsp_err && (rsp_len != '0);
  assign in_adv   = (state_q == ST_READ)  && xfer_done && !xfer_err;
  assign out_adv  = (state_q == ST_WRITE) && xfer_done && !xfer_err;

  asp_piece_track #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_in_trk (
    .clk(clk), .rst_n(rst_n),
    .load(in_load), .load_pos(rsp_pos), .load_len(rsp_len),
    .adv(in_adv), .adv_n(in_chunk),
    .addr(in_addr), .remain(in_rem)
  );

  asp_piece_track #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_out_trk (
    .clk(clk), .rst_n(rst_n),
    .load(out_load), .load_pos(rsp_pos), .load_len(rsp_len),
    .adv(out_adv), .adv_n(wr_len),
    .addr(out_addr), .remain(out_rem)
  );

  // Next state; ctx_req is only looked at where a new issue would start
  always_comb begin
    state_d = state_q;
    err_set = 1'b0;
    err_val = ERR_NONE;
    unique case (state_q)
      ST_IDLE:     if (go) state_d = ctx_req ? ST_SAVE : ST_IN_REQ;
      ST_IN_REQ:   if (req_ready) state_d = ST_IN_WAIT;
      ST_IN_WAIT:
        if (rsp_valid) begin
          if (rsp_err) begin
            state_d = ST_ERR; err_set = 1'b1; err_val = ERR_IN_RSP;
          end else if (rsp_len == '0) begin
            state_d = (out_used_q != '0) ? ST_FIN : ST_DONE;
          end else begin
            state_d = ctx_req ? ST_SAVE : ST_READ;
          end
        end
      ST_READ:
        if (xfer_done) begin
          if (xfer_err) begin
            state_d = ST_ERR; err_set = 1'b1; err_val = ERR_READ;
          end else begin
            state_d = ST_RUN_GO;
          end
        end
      ST_RUN_GO:   state_d = ST_RUN_WAIT;
      ST_RUN_WAIT:
        if (acc_done) begin
          if (acc_res_len == '0)
            state_d = ctx_req ? ST_SAVE : ((in_rem != '0) ? ST_READ : ST_IN_REQ);
          else
            state_d = ctx_req ? ST_SAVE : ((out_rem == '0) ? ST_OUT_REQ : ST_WRITE);
        end
      ST_OUT_REQ:  if (req_ready) state_d = ST_OUT_WAIT;
      ST_OUT_WAIT:
        if (rsp_valid) begin
          if (rsp_err) begin
            state_d = ST_ERR; err_set = 1'b1; err_val = ERR_OUT_RSP;
          end else if (rsp_len == '0) begin
            state_d = ST_ERR; err_set = 1'b1; err_val = ERR_OUT_EMPTY;
          end else begin
            state_d = ctx_req ? ST_SAVE : ST_WRITE;
          end
        end
      ST_WRITE:
        if (xfer_done) begin
          if (xfer_err) begin
            state_d = ST_ERR; err_set = 1'b1; err_val = ERR_WRITE;
          end else if (res_after != '0) begin
            state_d = ctx_req ? ST_SAVE : ST_OUT_REQ;
          end else begin
            state_d = ctx_req ? ST_SAVE : ((in_rem != '0) ? ST_READ : ST_IN_REQ);
          end
        end
      ST_FIN:      if (req_ready) state_d = ST_DONE;
      default:     state_d = state_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // Datapath registers
  always_comb begin
    chunk_en   = in_adv;
    res_en     = ((state_q == ST_RUN_WAIT) && acc_done) || out_adv;
    res_left_d = res_left_q;
    res_off_d  = res_off_q;
    if ((state_q == ST_RUN_WAIT) && acc_done) begin
      res_left_d = acc_res_len;
      res_off_d  = '0;
    end else if (out_adv) begin
      res_left_d = res_after;
      res_off_d  = res_off_q + SPM_W'(wr_len);
    end
    used_en    = out_load | out_adv;
    out_used_d = out_load ? '0 : (out_used_q + wr_len);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chunk_q    <= '0;
      res_left_q <= '0;
      res_off_q  <= '0;
      out_used_q <= '0;
    end else begin
      if (chunk_en) chunk_q <= in_chunk;
      if (res_en) begin
        res_left_q <= res_left_d;
        res_off_q  <= res_off_d;
      end
      if (used_en) out_used_q <= out_used_d;
    end
  end

  asp_err_hold #(.W(ERR_W)) u_err (
    .clk(clk), .rst_n(rst_n),
    .set(err_set), .code_in(err_val), .code(err_code)
  );

  // Output decode
  assign req_valid  = (state_q == ST_IN_REQ) || (state_q == ST_OUT_REQ) || (state_q == ST_FIN);
  assign req_chan   = (state_q == ST_OUT_REQ) || (state_q == ST_FIN);
  assign req_commit = (state_q == ST_FIN);
  assign req_nbytes = (state_q == ST_FIN) ? out_used_q : '0;

  assign xfer_valid = (state_q == ST_READ) || (state_q == ST_WRITE);
  assign xfer_write = (state_q == ST_WRITE);
  assign xfer_addr  = (state_q == ST_WRITE) ? out_addr : in_addr;
  assign xfer_len   = (state_q == ST_WRITE) ? wr_len : in_chunk;
  assign xfer_spm   = (state_q == ST_WRITE) ? res_off_q : '0;

  assign acc_start  = (state_q == ST_RUN_GO);
  assign acc_len    = chunk_q;

  assign st_done    = (state_q == ST_DONE);
  assign st_saved   = (state_q == ST_SAVE);
  assign st_err     = (state_q == ST_ERR);

endmodule

// File: rtl/asp_stream_ctrl_chk.sv
module asp_stream_ctrl_chk #(
  parameter int LEN_W     = 16,
  parameter int BUF_BYTES = 64,
  parameter int ADDR_W    = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_chan,
  input logic              req_commit,
  input logic [LEN_W-1:0]  req_nbytes,
  input logic              xfer_valid,
  input logic              xfer_done,
  input logic              xfer_write,
  input logic [ADDR_W-1:0] xfer_addr,
  input logic [LEN_W-1:0]  xfer_len,
  input logic              acc_start,
  input logic              st_done,
  input logic              st_saved,
  input logic              st_err,
  input logic [3:0]        err_code
);

  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_chan) && $stable(req_commit) && $stable(req_nbytes));

  assert_chunk_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> (xfer_len != '0) && (xfer_len <= LEN_W'(BUF_BYTES)));

  assert_xfer_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid && !xfer_done |=> xfer_valid && $stable(xfer_addr) && $stable(xfer_len) && $stable(xfer_write));

  assert_start_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_start |=> !acc_start);

  assert_done_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    st_done |=> st_done && !req_valid && !xfer_valid);

  assert_saved_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    st_saved |=> st_saved && !req_valid && !xfer_valid && !acc_start);

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    st_err |=> st_err && $stable(err_code) && (err_code != 4'd0));

  assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && xfer_valid));

endmodule

bind asp_stream_ctrl asp_stream_ctrl_chk #(
  .LEN_W(LEN_W), .BUF_BYTES(BUF_BYTES), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .req_valid(req_valid), .req_ready(req_ready), .req_chan(req_chan),
  .req_commit(req_commit), .req_nbytes(req_nbytes),
  .xfer_valid(xfer_valid), .xfer_done(xfer_done), .xfer_write(xfer_write),
  .xfer_addr(xfer_addr), .xfer_len(xfer_len),
  .acc_start(acc_start),
  .st_done(st_done), .st_saved(st_saved), .st_err(st_err), .err_code(err_code)
);

// File: tb/asp_stream_ctrl_bench.sv
`timescale 1ns/1ps
module asp_stream_ctrl_bench;

  localparam int ADDR_W = 32;
  localparam int LEN_W  = 16;
  localparam int BUFB   = 64;
  localparam int SPM_W  = $clog2(BUFB);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rst_n, go, ctx_req;
  logic              req_valid, req_chan, req_commit, req_ready;
  logic [LEN_W-1:0]  req_nbytes;
  logic              rsp_valid, rsp_err;
  logic [ADDR_W-1:0] rsp_pos;
  logic [LEN_W-1:0]  rsp_len;
  logic              xfer_valid, xfer_write, xfer_done, xfer_err;
  logic [ADDR_W-1:0] xfer_addr;
  logic [LEN_W-1:0]  xfer_len;
  logic [SPM_W-1:0]  xfer_spm;
  logic              acc_start, acc_done;
  logic [LEN_W-1:0]  acc_len, acc_res_len;
  logic              st_done, st_saved, st_err;
  logic [3:0]        err_code;

  asp_stream_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .BUF_BYTES(BUFB)) u_asp_stream_ctrl (
    .clk(clk), .rst_n(rst_n), .go(go), .ctx_req(ctx_req),
    .req_valid(req_valid), .req_chan(req_chan), .req_commit(req_commit),
    .req_nbytes(req_nbytes), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_pos(rsp_pos), .rsp_len(rsp_len),
    .xfer_valid(xfer_valid), .xfer_write(xfer_write), .xfer_addr(xfer_addr),
    .xfer_len(xfer_len), .xfer_spm(xfer_spm), .xfer_done(xfer_done), .xfer_err(xfer_err),
    .acc_start(acc_start), .acc_len(acc_len), .acc_done(acc_done), .acc_res_len(acc_res_len),
    .st_done(st_done), .st_saved(st_saved), .st_err(st_err), .err_code(err_code)
  );

  int n_run  = 0;
  int n_fail = 0;

  task automatic check_eq(input string tag, input string what, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; go = 1'b0; ctx_req = 1'b0; req_ready = 1'b0;
    rsp_valid = 1'b0; rsp_err = 1'b0; rsp_pos = '0; rsp_len = '0;
    xfer_done = 1'b0; xfer_err = 1'b0; acc_done = 1'b0; acc_res_len = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_go();
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
  endtask

  // Await a message, check it, accept it for one cycle.
  task automatic exp_req(input string tag, input bit chan, input bit commit, input int nb);
    int n = 0;
    while (!req_valid && n < 100) begin @(negedge clk); n++; end
    check_eq(tag, "req_valid", req_valid, 1);
    check_eq(tag, "req_chan", req_chan, chan);
    check_eq(tag, "req_commit", req_commit, commit);
    if (commit) check_eq(tag, "req_nbytes", req_nbytes, nb);
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
  endtask

  task automatic give_rsp(input bit err, input int pos, input int len);
    rsp_valid = 1'b1; rsp_err = err; rsp_pos = ADDR_W'(pos); rsp_len = LEN_W'(len);
    @(negedge clk);
    rsp_valid = 1'b0; rsp_err = 1'b0;
  endtask

  task automatic exp_xfer(input string tag, input bit wr, input int addr, input int len,
                          input int spm, input bit err);
    int n = 0;
    while (!xfer_valid && n < 100) begin @(negedge clk); n++; end
    check_eq(tag, "xfer_valid", xfer_valid, 1);
    check_eq(tag, "xfer_write", xfer_write, wr);
    check_eq(tag, "xfer_addr", xfer_addr, addr);
    check_eq(tag, "xfer_len", xfer_len, len);
    check_eq(tag, "xfer_spm", xfer_spm, spm);
    xfer_done = 1'b1; xfer_err = err;
    @(negedge clk);
    xfer_done = 1'b0; xfer_err = 1'b0;
  endtask

  task automatic exp_acc(input string tag, input int len, input int res);
    int n = 0;
    while (!acc_start && n < 100) begin @(negedge clk); n++; end
    check_eq(tag, "acc_start", acc_start, 1);
    check_eq(tag, "acc_len", acc_len, len);
    @(negedge clk);
    check_eq("R4", "acc_start one cycle", acc_start, 0);
    acc_done = 1'b1; acc_res_len = LEN_W'(res);
    @(negedge clk);
    acc_done = 1'b0;
  endtask

  task automatic quiet_for(input string tag, input int cycles);
    bit seen = 1'b0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (req_valid || xfer_valid || acc_start) seen = 1'b1;
    end
    check_eq(tag, "no activity", seen, 0);
  endtask

  task automatic t_reset();
    do_reset();
    check_eq("R1", "req_valid", req_valid, 0);
    check_eq("R1", "xfer_valid", xfer_valid, 0);
    check_eq("R1", "status", {st_done, st_saved, st_err}, 0);
    check_eq("R1", "err_code", err_code, 0);
    quiet_for("R1", 5);
  endtask

  task automatic t_single();
    do_reset();
    pulse_go();
    exp_req("R2", 1'b0, 1'b0, 0);
    give_rsp(1'b0, 'h1000, 40);
    exp_xfer("R3", 1'b0, 'h1000, 40, 0, 1'b0);
    exp_acc("R4", 40, 24);
    exp_req("R5", 1'b1, 1'b0, 0);
    give_rsp(1'b0, 'h8000, 100);
    exp_xfer("R5", 1'b1, 'h8000, 24, 0, 1'b0);
    exp_req("R6", 1'b0, 1'b0, 0);
    give_rsp(1'b0, 0, 0);
    exp_req("R7", 1'b1, 1'b1, 24);
    @(negedge clk);
    check_eq("R7", "st_done", st_done, 1);
    quiet_for("R7", 4);
  endtask

  task automatic t_long_piece();
    do_reset();
    pulse_go();
    exp_req("R2", 1'b0, 1'b0, 0);
    give_rsp(1'b0, 'h2000, 150);
    exp_xfer("R3", 1'b0, 'h2000, 64, 0, 1'b0);
    exp_acc("R4", 64, 64);
    exp_req("R5", 1'b1, 1'b0, 0);
    give_rsp(1'b0, 'h8000, 200);
    exp_xfer("R5", 1'b1, 'h8000, 64, 0, 1'b0);
    exp_xfer("R6", 1'b0, 'h2040, 64, 0, 1'b0);
    exp_acc("R4", 64, 64);
    exp_xfer("R5", 1'b1, 'h8040, 64, 0, 1'b0);
    exp_xfer("R6", 1'b0, 'h2080, 22, 0, 1'b0);
    exp_acc("R4", 22, 22);
    exp_xfer("R5", 1'b1, 'h8080, 22, 0, 1'b0);
    exp_req("R6", 1'b0, 1'b0, 0);
    give_rsp(1'b0, 0, 0);
    exp_req("R7", 1'b1, 1'b1, 150);
    @(negedge clk);
    check_eq("R7", "st_done", st_done, 1);
  endtask

  task automatic t_split_output();
    do_reset();
    pulse_go();
    exp_req("R2", 1'b0, 1'b0, 0);
    give_rsp(1'b0, 'h3000, 50);
    exp_xfer("R3", 1'b0, 'h3000, 50, 0, 1'b0);
    exp_acc("R4", 50, 50);
    exp_req("R5", 1'b1, 1'b0, 0);
    give_rsp(1'b0, 'h9000, 30);
    exp_xfer("R5", 1'b1, 'h9000, 30, 0, 1'b0);
    exp_req("R5", 1'b1, 1'b0, 0);
    give_rsp(1'b0, 'hA000, 100);
    exp_xfer("R5", 1'b1, 'hA000, 20, 30, 1'b0);
    exp_req("R6", 1'b0, 1'b0, 0);
    give_rsp(1'b0, 0, 0);
    exp_req("R7", 1'b1, 1'b1, 20);
    @(negedge clk);
    check_eq("R7", "st_done", st_done, 1);
  endtask

  task automatic t_empty_file();
    do_reset();
    pulse_go();
    exp_req("R2", 1'b0, 1'b0, 0);
    give_rsp(1'b0, 'h100, 0);
    @(negedge clk);
    check_eq("R7", "st_done without commit", st_done, 1);
    quiet_for("R7", 4);
  endtask

  task automatic t_ctx_mid_read();
    do_reset();
    pulse_go();
    exp_req("R2", 1'b0, 1'b0, 0);
    give_rsp(1'b0, 'h4000, 16);
    ctx_req = 1'b1;
    repeat (4) @(negedge clk);
    check_eq("R8", "read kept in flight", xfer_valid, 1);
    check_eq("R8", "not yet saved", st_saved, 0);
    exp_xfer("R8", 1'b0, 'h4000, 16, 0, 1'b0);
    exp_acc("R8", 16, 16);
    @(negedge clk);
    check_eq("R8", "st_saved", st_saved, 1);
    quiet_for("R8", 5);
    ctx_req = 1'b0;
  endtask

  task automatic t_ctx_after_write();
    do_reset();
    pulse_go();
    exp_req("R2", 1'b0, 1'b0, 0);
    give_rsp(1'b0, 'h5000, 8);
    exp_xfer("R3", 1'b0, 'h5000, 8, 0, 1'b0);
    exp_acc("R4", 8, 8);
    exp_req("R5", 1'b1, 1'b0, 0);
    give_rsp(1'b0, 'hB000, 64);
    ctx_req = 1'b1;
    exp_xfer("R8", 1'b1, 'hB000, 8, 0, 1'b0);
    check_eq("R8", "st_saved", st_saved, 1);
    quiet_for("R8", 5);
    ctx_req = 1'b0;
  endtask

  task automatic t_errors();
    do_reset();
    pulse_go();
    exp_req("R2", 1'b0, 1'b0, 0);
    give_rsp(1'b0, 'h1000, 10);
    exp_xfer("R9", 1'b0, 'h1000, 10, 0, 1'b1);
    check_eq("R9", "st_err read", st_err, 1);
    check_eq("R9", "code read", err_code, 3);
    pulse_go();
    ctx_req = 1'b1;
    quiet_for("R9", 5);
    ctx_req = 1'b0;
    check_eq("R9", "code sticky", err_code, 3);

    do_reset();
    pulse_go();
    exp_req("R2", 1'b0, 1'b0, 0);
    give_rsp(1'b0, 'h1000, 10);
    exp_xfer("R3", 1'b0, 'h1000, 10, 0, 1'b0);
    exp_acc("R4", 10, 10);
    exp_req("R5", 1'b1, 1'b0, 0);
    give_rsp(1'b0, 'hC000, 0);
    check_eq("R9", "code empty out", err_code, 5);

    do_reset();
    pulse_go();
    exp_req("R2", 1'b0, 1'b0, 0);
    give_rsp(1'b1, 'h1000, 10);
    check_eq("R9", "code in reply", err_code, 1);
    check_eq("R9", "st_err reply", st_err, 1);
    quiet_for("R9", 3);

    do_reset();
    pulse_go();
    exp_req("R2", 1'b0, 1'b0, 0);
    give_rsp(1'b0, 'h1000, 4);
    exp_xfer("R3", 1'b0, 'h1000, 4, 0, 1'b0);
    exp_acc("R4", 4, 4);
    exp_req("R5", 1'b1, 1'b0, 0);
    give_rsp(1'b0, 'hD000, 16);
    exp_xfer("R9", 1'b1, 'hD000, 4, 0, 1'b1);
    check_eq("R9", "code write", err_code, 4);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_single();
    t_long_piece();
    t_split_output();
    t_empty_file();
    t_ctx_mid_read();
    t_ctx_after_write();
    t_errors();
    summary();
    $finish;
  end

endmodule